// File: doc/BRIEF.md
# I2C-Controlled Eight-Line GPIO Expander

This block is an I2C-bus target that gives a host eight general-purpose lines. Each line is set on its own to be an input or an output. Four byte-wide registers sit behind a register pointer. The first data byte of every write transaction loads that pointer. Any bytes after it go to the selected register. A read in a later transaction, or after a repeated START, returns the selected register. An active-low interrupt tells the host that an input line has moved away from the value captured by the last input-register read.

The bus side runs on a system clock that is at least ten times faster than SCL. SCL and SDA are oversampled through synchronizer flops, and START and STOP are found from SDA edges while SCL is high. The target never drives SDA high. It only requests a low level through `sda_oe`, so SCL rates from DC to 400 kHz work with the usual open-drain wiring. The `irq_n` output is meant to drive an open-drain pad, and its low level means a change is pending. Three strap inputs supply the low bits of the 7-bit target address.

Top module: `i2c_pin_expander`

## Requirements
- R1: While `rst` is high and on the cycle after it, the output register is 0xFF, the polarity register is 0x00 and the configuration register is 0xFF (every line an input, so `pin_oe` = 0x00). In the same window `irq_n` is 1, and `sda_oe` is 0 until a transaction begins.
- R2: The target address is `{ADDR_HI, addr_sel}`, with `ADDR_HI` as the upper four bits. The target pulls SDA low in the ninth clock only when the seven received address bits match it. After a mismatch it drives nothing and ignores every byte until the next START.
- R3: In a write transaction, the byte after the address is a command byte, and the target acknowledges it. Its two least significant bits select the register: 0 input, 1 output, 2 polarity inversion, 3 configuration. Its upper six bits are ignored.
- R4: Each data byte after the command byte is acknowledged and written to the selected register, and the pointer does not advance, so the last byte wins. Writes that select the input register change nothing.
- R5: A read transaction (address bit 0 = 1) returns the selected register, most significant bit first. Every byte of a multi-byte read returns the same register.
- R6: `pin_oe[i]` is the inverse of configuration bit i, where 1 means input. `pin_o` always equals the output register.
- R7: A read of the input register returns the captured line levels XOR the polarity register. Reads of the other registers are not inverted.
- R8: The input register captures the synchronized line levels each time an input-register read byte is loaded for sending. A line configured as output reads back at its pad level.
- R9: `irq_n` goes low when any line configured as input differs from the matching bit of the input register. Lines configured as output never cause it.
- R10: `irq_n` returns high after an input-register read, or when the input lines go back to the captured values.
- R11: When the master NACKs a read byte, the target releases SDA and drives nothing until the next START.
- R12: A START or STOP at any point abandons the current byte without writing it. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level sensed from the pad |
| sda_i | input | 1 | Bus data level sensed from the pad |
| sda_oe | output | 1 | 1 pulls the SDA pad low |
| addr_sel | input | 3 | Low three bits of the target address (static strap) |
| pin_i | input | 8 | Levels sensed on the eight GPIO pads |
| pin_o | output | 8 | Output register value for the pad drivers |
| pin_oe | output | 8 | Per-line output enable, 1 = drive |
| irq_n | output | 1 | Active-low change-detect interrupt, for an open-drain pad |

## Verification
The bench aims at several corner cases. One is a write of three bytes to a single pointer: a design that auto-incremented would spread them over the polarity and configuration registers and change `pin_oe`. Another is a byte sent after the master's NACK: a target that failed to release would return register bits where the bus must read all ones. The bench also checks that an interrupt from a line configured as output stays quiet. It checks that the interrupt clears on an input read and also when a line goes back to its captured value, since a design that latched the flag would hold `irq_n` low. Finally, a START or STOP in the middle of a byte must leave the output register untouched, and a wrong address must get no ACK; a design that committed partial bytes or answered every address would corrupt `pin_o`.

// File: rtl/pex_pkg.sv
package pex_pkg;

    localparam int REG_W = 8;
    localparam int PTR_W = 2;
    localparam int ADR_W = 7;

    localparam logic [REG_W-1:0] OUT_RST = 8'hFF;
    localparam logic [REG_W-1:0] POL_RST = 8'h00;
    localparam logic [REG_W-1:0] CFG_RST = 8'hFF;

    typedef enum logic [PTR_W-1:0] {
        RSEL_IN  = 2'd0,
        RSEL_OUT = 2'd1,
        RSEL_POL = 2'd2,
        RSEL_CFG = 2'd3
    } rsel_e;

    typedef enum logic [3:0] {
        T_IDLE,
        T_ADDR,
        T_AACK,
        T_CMD,
        T_CACK,
        T_WR,
        T_WACK,
        T_RD,
        T_RACK
    } tstate_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic             en;
        rsel_e            sel;
        logic [REG_W-1:0] data;
    } wr_req_t;

    function automatic logic [ADR_W-1:0] make_addr(input logic [3:0] hi, input logic [2:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/pex_sync_vec.sv
module pex_sync_vec #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter bit             USE_RST = 1'b1,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        if (USE_RST) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
        end else begin : g_free
            // pad levels keep flowing during reset so the input register can track them
            logic unused_rst;
            assign unused_rst = rst;
            always_ff @(posedge clk) begin
                stg[0] <= d;
                for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pex_bus_events.sv
module pex_bus_events
    import pex_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);

    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/pex_i2c_target.sv
module pex_i2c_target
    import pex_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [ADR_W-1:0] own_addr,
    input  logic [REG_W-1:0] rd_data,
    output logic             sda_oe,
    output wr_req_t          wr,
    output rsel_e            ptr,
    output logic             load_rd
);

    localparam int CNT_W = $clog2(REG_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(REG_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REG_W - 1);

    tstate_e          st;
    logic [CNT_W-1:0] cnt;
    logic [REG_W-1:0] sh;
    logic             rw;
    logic             nack;
    logic             rx_st;
    logic             quiet;

    assign rx_st = (st == T_ADDR) || (st == T_CMD) || (st == T_WR);
    assign quiet = ~ev.start & ~ev.stop;

    // a byte for the master is fetched on the SCL fall that ends an ACK phase
    assign load_rd = ev.scl_fall & quiet &
                     (((st == T_AACK) & rw) | ((st == T_RACK) & ~nack));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= T_IDLE;
            cnt     <= '0;
            sh      <= '0;
            rw      <= 1'b0;
            nack    <= 1'b1;
            ptr     <= RSEL_IN;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                st     <= T_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                st     <= T_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (rx_st) begin
                if (ev.scl_rise && cnt != CNT_FULL) begin
                    sh  <= {sh[REG_W-2:0], ev.sda};
                    cnt <= cnt + 1'b1;
                end else if (ev.scl_fall && cnt == CNT_FULL) begin
                    cnt <= '0;
                    if (st == T_ADDR) begin
                        if (sh[REG_W-1:1] == own_addr) begin
                            rw     <= sh[0];
                            sda_oe <= 1'b1;
                            st     <= T_AACK;
                        end else begin
                            st <= T_IDLE;
                        end
                    end else if (st == T_CMD) begin
                        ptr    <= rsel_e'(sh[PTR_W-1:0]);
                        sda_oe <= 1'b1;
                        st     <= T_CACK;
                    end else begin
                        wr.en   <= 1'b1;
                        wr.sel  <= ptr;
                        wr.data <= sh;
                        sda_oe  <= 1'b1;
                        st      <= T_WACK;
                    end
                end
            end else begin
                case (st)
                    T_AACK, T_CACK, T_WACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (load_rd) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[REG_W-1];
                                st     <= T_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= (st == T_AACK) ? T_CMD : T_WR;
                            end
                        end
                    end
                    T_RD: begin
                        if (ev.scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                sda_oe <= 1'b0;
                                nack   <= 1'b1;
                                st     <= T_RACK;
                            end else begin
                                sh     <= {sh[REG_W-2:0], 1'b0};
                                sda_oe <= ~sh[REG_W-2];
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    T_RACK: begin
                        if (ev.scl_rise) begin
                            nack <= ev.sda;
                        end else if (ev.scl_fall) begin
                            cnt <= '0;
                            if (load_rd) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[REG_W-1];
                                st     <= T_RD;
                            end else begin
                                st <= T_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pex_regs.sv
module pex_regs
    import pex_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] pin_s,
    input  wr_req_t          wr,
    input  rsel_e            ptr,
    input  logic             load_rd,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] out_q,
    output logic [REG_W-1:0] cfg_q,
    output logic [REG_W-1:0] in_q,
    output logic             irq_n
);

    logic [REG_W-1:0] pol_q;
    logic [REG_W-1:0] moved;

    assign moved = (pin_s ^ in_q) & cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= OUT_RST;
            pol_q <= POL_RST;
            cfg_q <= CFG_RST;
            in_q  <= pin_s;
            irq_n <= 1'b1;
        end else begin
            if (wr.en) begin
                case (wr.sel)
                    RSEL_OUT: out_q <= wr.data;
                    RSEL_POL: pol_q <= wr.data;
                    RSEL_CFG: cfg_q <= wr.data;
                    default:  ;
                endcase
            end
            if (load_rd && ptr == RSEL_IN) in_q <= pin_s;
            irq_n <= ~|moved;
        end
    end

    always_comb begin
        case (ptr)
            RSEL_IN:  rd_data = pin_s ^ pol_q;
            RSEL_OUT: rd_data = out_q;
            RSEL_POL: rd_data = pol_q;
            default:  rd_data = cfg_q;
        endcase
    end

endmodule

// File: rtl/i2c_pin_expander.sv
module i2c_pin_expander
    import pex_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b0100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [2:0]       addr_sel,
    input  logic [REG_W-1:0] pin_i,
    output logic [REG_W-1:0] pin_o,
    output logic [REG_W-1:0] pin_oe,
    output logic             irq_n
);

    logic [1:0]       bus_s;
    logic [REG_W-1:0] pin_s;
    bus_ev_t          ev;
    wr_req_t          wr_req;
    rsel_e            ptr;
    logic             load_rd;
    logic [REG_W-1:0] rd_data;
    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] in_q;

    // flat views for the bound checker
    logic             wr_en_s;
    logic [PTR_W-1:0] wr_sel_s;
    logic [PTR_W-1:0] ptr_s;
    logic             stop_s;

    pex_sync_vec #(
        .W(2), .STAGES(SYNC_STAGES), .USE_RST(1'b1), .RST_VAL(2'b11)
    ) u_bus_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
    );

    pex_sync_vec #(
        .W(REG_W), .STAGES(SYNC_STAGES), .USE_RST(1'b0), .RST_VAL('0)
    ) u_pin_sync (
        .clk(clk), .rst(rst), .d(pin_i), .q(pin_s)
    );

    pex_bus_events u_events (
        .clk(clk), .rst(rst), .scl_s(bus_s[1]), .sda_s(bus_s[0]), .ev(ev)
    );

    pex_i2c_target u_target (
        .clk(clk), .rst(rst), .ev(ev),
        .own_addr(make_addr(ADDR_HI, addr_sel)),
        .rd_data(rd_data), .sda_oe(sda_oe), .wr(wr_req),
        .ptr(ptr), .load_rd(load_rd)
    );

    pex_regs u_regs (
        .clk(clk), .rst(rst), .pin_s(pin_s), .wr(wr_req), .ptr(ptr),
        .load_rd(load_rd), .rd_data(rd_data), .out_q(pin_o),
        .cfg_q(cfg_q), .in_q(in_q), .irq_n(irq_n)
    );

    assign pin_oe   = ~cfg_q;
    assign wr_en_s  = wr_req.en;
    assign wr_sel_s = wr_req.sel;
    assign ptr_s    = ptr;
    assign stop_s   = ev.stop;

endmodule

// File: rtl/pex_checker.sv
module pex_checker
    import pex_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_sel,
    input logic [PTR_W-1:0] ptr,
    input logic             load_rd,
    input logic             stop_ev,
    input logic             sda_oe,
    input logic [REG_W-1:0] pin_o,
    input logic [REG_W-1:0] pin_oe,
    input logic [REG_W-1:0] pin_s,
    input logic [REG_W-1:0] in_q,
    input logic [REG_W-1:0] cfg_q,
    input logic             irq_n
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pin_o == OUT_RST) && (pin_oe == '0) && irq_n);

    // R6
    drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pin_oe) && $stable(pin_o));

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> $past(|((pin_s ^ in_q) & cfg_q)));

    // R4
    input_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == PTR_W'(0) && !load_rd) |=> $stable(in_q));

    // R8
    input_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (load_rd && ptr == PTR_W'(0)) |=> (in_q == $past(pin_s)));

endmodule

bind i2c_pin_expander pex_checker u_pex_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en_s), .wr_sel(wr_sel_s), .ptr(ptr_s),
    .load_rd(load_rd), .stop_ev(stop_s), .sda_oe(sda_oe), .pin_o(pin_o),
    .pin_oe(pin_oe), .pin_s(pin_s), .in_q(in_q), .cfg_q(cfg_q), .irq_n(irq_n)
);

// File: tb/i2c_pin_expander_bench.sv
module i2c_pin_expander_bench;

    localparam logic [3:0] HI  = 4'b0100;
    localparam logic [2:0] LO  = 3'b101;
    localparam logic [6:0] TGT = {HI, LO};
    localparam int Q = 10;

    // 4-unit period: 250 MHz
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst   = 1'b1;
    logic       scl   = 1'b1;
    logic       m_low = 1'b0;
    logic [7:0] ext   = 8'h3A;
    logic       busy  = 1'b1;
    logic       done  = 1'b0;

    logic       sda_oe, irq_n;
    logic [7:0] pin_o, pin_oe, pin_i;
    logic       sda_line;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic [7:0] m_out = 8'hFF;
    logic [7:0] m_pol = 8'h00;
    logic [7:0] m_cfg = 8'hFF;
    logic [7:0] m_in  = 8'h3A;

    assign sda_line = ~(m_low | sda_oe);
    assign pin_i    = (pin_oe & pin_o) | (~pin_oe & ext);

    i2c_pin_expander #(.ADDR_HI(HI), .SYNC_STAGES(2)) u_i2c_pin_expander (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(LO), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pad_model();
        return (~m_cfg & m_out) | (m_cfg & ext);
    endfunction

    // per-clock comparison against the model whenever the bus is quiet
    always @(negedge clk) begin
        if (!rst && !busy && !done) begin
            chk("R6 pin_o vs model", {24'd0, pin_o}, {24'd0, m_out});
            chk("R6 pin_oe vs model", {24'd0, pin_oe}, {24'd0, ~m_cfg});
            chk("R9/R10 irq_n vs model", {31'd0, irq_n},
                {31'd0, ~|((ext ^ m_in) & m_cfg)});
            chk("R11 sda idle", {31'd0, sda_oe}, 32'd0);
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        waitc(12);
        busy = 1'b0;
    endtask

    task automatic bus_start();
        m_low = 1'b0; waitc(Q);
        scl = 1'b1;   waitc(Q);
        m_low = 1'b1; waitc(Q);
        scl = 1'b0;   waitc(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; waitc(Q);
        scl = 1'b1;   waitc(Q);
        m_low = 1'b0; waitc(2*Q);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; waitc(Q);
        scl = 1'b1; waitc(2*Q);
        scl = 1'b0; waitc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; waitc(Q);
        scl = 1'b1;   waitc(Q);
        acked = ~sda_line;
        waitc(Q);
        scl = 1'b0;   waitc(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            waitc(Q);
            scl = 1'b1; waitc(Q);
            b[i] = sda_line;
            waitc(Q);
            scl = 1'b0;
        end
        waitc(Q);
        m_low = give_ack; waitc(Q);
        scl = 1'b1; waitc(2*Q);
        scl = 1'b0; waitc(Q);
        m_low = 1'b0;
    endtask

    task automatic write_seq(input logic [7:0] cmd, input int n,
                             input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input string tag);
        logic ak;
        logic [7:0] d;
        busy = 1'b1;
        bus_start();
        send_byte({TGT, 1'b0}, ak); chk({tag, " R2 addr ack"}, {31'd0, ak}, 32'd1);
        send_byte(cmd, ak);         chk({tag, " R3 cmd ack"}, {31'd0, ak}, 32'd1);
        for (int i = 0; i < n; i++) begin
            d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
            send_byte(d, ak);
            chk({tag, " R4 data ack"}, {31'd0, ak}, 32'd1);
            case (cmd[1:0])
                2'd1: m_out = d;
                2'd2: m_pol = d;
                2'd3: m_cfg = d;
                default: ;
            endcase
        end
        bus_stop();
        settle();
    endtask

    task automatic read_chk(input logic [1:0] sel, input int n, input string tag);
        logic ak;
        logic [7:0] got, exp;
        busy = 1'b1;
        bus_start();
        send_byte({TGT, 1'b0}, ak); chk({tag, " R2 addr ack"}, {31'd0, ak}, 32'd1);
        send_byte({6'd0, sel}, ak); chk({tag, " R3 cmd ack"}, {31'd0, ak}, 32'd1);
        bus_start();
        send_byte({TGT, 1'b1}, ak); chk({tag, " R12 restart addr ack"}, {31'd0, ak}, 32'd1);
        for (int i = 0; i < n; i++) begin
            case (sel)
                2'd0: begin m_in = pad_model(); exp = m_in ^ m_pol; end
                2'd1: exp = m_out;
                2'd2: exp = m_pol;
                default: exp = m_cfg;
            endcase
            recv_byte(got, i != n - 1);
            chk(tag, {24'd0, got}, {24'd0, exp});
        end
        bus_stop();
        settle();
    endtask

    task automatic set_pins(input logic [7:0] v);
        busy = 1'b1;
        ext = v;
        settle();
    endtask

    initial begin
        logic ak;
        logic [7:0] got;
        waitc(10);
        rst = 1'b0;
        waitc(4);
        // R1 reset state at the ports
        chk("R1 pin_o reset", {24'd0, pin_o}, 32'hFF);
        chk("R1 pin_oe reset", {24'd0, pin_oe}, 32'h00);
        chk("R1 irq_n reset", {31'd0, irq_n}, 32'd1);
        chk("R1 sda_oe reset", {31'd0, sda_oe}, 32'd0);
        busy = 1'b0;
        waitc(8);

        // R1 R5 default register contents
        read_chk(2'd1, 1, "R1 R5 out default");
        read_chk(2'd2, 1, "R1 R5 pol default");
        read_chk(2'd3, 1, "R1 R5 cfg default");
        read_chk(2'd0, 1, "R5 R7 in default");

        // R6 directions and output value
        write_seq(8'h01, 1, 8'hA5, 8'h00, 8'h00, "R6 out write");
        write_seq(8'h03, 1, 8'h0F, 8'h00, 8'h00, "R6 cfg write");
        chk("R6 pin_oe", {24'd0, pin_oe}, 32'hF0);
        chk("R6 pin_o", {24'd0, pin_o}, 32'hA5);
        read_chk(2'd3, 2, "R5 cfg two bytes");

        // R4 no auto-increment: last byte wins, cfg untouched
        write_seq(8'h02, 3, 8'h11, 8'h22, 8'h3C, "R4 pol burst");
        chk("R4 cfg untouched by burst", {24'd0, pin_oe}, 32'hF0);
        read_chk(2'd2, 3, "R4 R5 pol repeat read");

        // R3 upper command bits ignored: 0xFD selects output
        write_seq(8'hFD, 1, 8'h5C, 8'h00, 8'h00, "R3 high cmd bits");
        chk("R3 pin_o after 0xFD", {24'd0, pin_o}, 32'h5C);

        // R4 write to input register ignored; R7 R8 inverted read with output readback
        write_seq(8'h00, 1, 8'h55, 8'h00, 8'h00, "R4 input write");
        read_chk(2'd0, 1, "R7 R8 input read");

        // R9 input line change raises irq
        set_pins(ext ^ 8'h02);
        chk("R9 irq on input change", {31'd0, irq_n}, 32'd0);
        // R10 read clears it
        read_chk(2'd0, 1, "R8 capture read");
        chk("R10 irq cleared by read", {31'd0, irq_n}, 32'd1);
        // R9 output-configured line never raises it
        set_pins(ext ^ 8'h80);
        chk("R9 output line ignored", {31'd0, irq_n}, 32'd1);
        // R10 line returns to captured value
        set_pins(ext ^ 8'h04);
        chk("R9 irq again", {31'd0, irq_n}, 32'd0);
        set_pins(ext ^ 8'h04);
        chk("R10 irq cleared by return", {31'd0, irq_n}, 32'd1);

        // R2 wrong address: no ACK, bytes ignored
        busy = 1'b1;
        bus_start();
        send_byte({TGT ^ 7'h01, 1'b0}, ak); chk("R2 mismatch nack", {31'd0, ak}, 32'd0);
        send_byte(8'h01, ak);               chk("R2 ignored cmd", {31'd0, ak}, 32'd0);
        send_byte(8'h00, ak);               chk("R2 ignored data", {31'd0, ak}, 32'd0);
        bus_stop();
        settle();
        read_chk(2'd1, 1, "R2 out unchanged");

        // R11 NACK ends the read; following clocks see a released bus
        busy = 1'b1;
        bus_start();
        send_byte({TGT, 1'b0}, ak);
        send_byte(8'h01, ak);
        bus_start();
        send_byte({TGT, 1'b1}, ak);
        recv_byte(got, 1'b0);
        chk("R11 byte before nack", {24'd0, got}, {24'd0, m_out});
        recv_byte(got, 1'b0);
        chk("R11 released after nack", {24'd0, got}, 32'hFF);
        bus_stop();
        settle();

        // R12 STOP mid-byte discards it
        busy = 1'b1;
        bus_start();
        send_byte({TGT, 1'b0}, ak);
        send_byte(8'h01, ak);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        settle();
        chk("R12 stop mid-byte", {24'd0, pin_o}, {24'd0, m_out});

        // R12 repeated START mid-byte then a full write
        busy = 1'b1;
        bus_start();
        send_byte({TGT, 1'b0}, ak);
        send_byte(8'h01, ak);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte({TGT, 1'b0}, ak); chk("R12 restart ack", {31'd0, ak}, 32'd1);
        send_byte(8'h01, ak);
        send_byte(8'h96, ak);
        m_out = 8'h96;
        bus_stop();
        settle();
        chk("R12 write after restart", {24'd0, pin_o}, 32'h96);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule